// File: doc/BRIEF.md
# Serial Port Handshake and Interrupt Controller

This block sits between a byte-wide serial transceiver core and the host bus. It holds three software registers: a line control word, an interrupt enable mask and a receive fill threshold. A small single-cycle Wishbone-style slave port writes and reads them. From these registers and the live signals of the transceiver core, the block produces three results. It grants or withholds permission for the transmitter to begin a new character, based on the incoming clear-to-send level. It drives the outgoing request-to-send line, either from a software-forced value or automatically from the receive FIFO fill level. It folds the eight core event flags into two masked interrupt lines, one for transmitter events and one for receiver events.

The serialiser, deserialiser, FIFOs and baud generator are outside the block. The transceiver core supplies its status flags, its receive FIFO count and a busy flag, and it consumes the transmit permission. The request-to-send output and both interrupt lines come from flops, so they are glitch-free.

Top module: `shk_top`

## Requirements
- R1: Each bus access (`bus_stb` and `bus_cyc` both high while `bus_ack` is low) is answered by `bus_ack` high in the following clock cycle, for exactly one cycle. A write takes effect on that same edge.
- R2: Register addresses are 0 for line control, 1 for interrupt mask and 2 for receive threshold. A read returns the stored value, zero-extended. Line control stores bits 2..0 only, and the threshold stores bits 5..0 only. Any other address reads 0, and a write to it changes no register.
- R3: `irq[0]` is high when any of `stat_in[3:0]` is high together with the mask bit of the same position (mask register bits 3..0).
- R4: `irq[1]` is high when any of `stat_in[7:4]` is high together with the mask bit of the same position (mask register bits 7..4).
- R5: When line control bit 0 (clear-to-send gating) is 1, `cts_n` is 1 and `tx_busy` is 0, `tx_permit` is 0. When gating is 0, or `cts_n` is 0, `tx_permit` is 1. This path is combinational.
- R6: While `tx_busy` is 1, `tx_permit` is 1 whatever the level of `cts_n` and the gating bit, so a character in progress always completes.
- R7: When line control bit 1 (force) is 1, `rts` equals line control bit 2.
- R8: When line control bit 1 is 0, `rts` is 1 exactly when `rx_count` is strictly greater than the threshold register. It is 0 when the count equals the threshold.
- R9: A synchronous active-high `rst` clears all three registers and the read data, and drives `rts`, `irq` and `bus_ack` low.
- R10: `rts` and `irq` are registered. They reflect their inputs one clock edge after those inputs change, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | Bus strobe |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_adr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle access acknowledge |
| stat_in | input | 8 | Core event flags: 3..0 transmitter, 7..4 receiver |
| rx_count | input | 6 | Receive FIFO fill count |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_permit | output | 1 | Transmitter may start a new character |
| cts_n | input | 1 | Clear to send, active low |
| rts | output | 1 | Request to send |
| irq | output | 2 | Bit 0 transmitter interrupt, bit 1 receiver interrupt |

## Verification
The bench builds the block with its default parameters: an 8-bit status vector split into two 4-bit interrupt groups, a 6-bit FIFO count and the strict threshold comparison. The 6-bit count lets the bench drive the threshold extremes 0 and 63. It also reaches the equal-count boundary where the strict compare must keep `rts` low. With only two groups, both interrupt lines and their crossed-mask cases can be covered in a short vector table.

// File: rtl/shk_pkg.sv
`timescale 1ns/1ps
package shk_pkg;
   // Line control fields; bit order is decoded by software
   typedef struct packed {
      logic rts_val;    // bit 2
      logic force_rts;  // bit 1
      logic cts_gate;   // bit 0
   } line_ctrl_t;

   localparam int LINE_W = 3;
endpackage

// File: rtl/shk_regs.sv
`timescale 1ns/1ps
module shk_regs
   import shk_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int DATA_W   = 8,
   parameter int STATUS_W = 8,
   parameter int CNT_W    = 6,
   parameter logic [ADDR_W-1:0] A_LINE = 0,
   parameter logic [ADDR_W-1:0] A_MASK = 1,
   parameter logic [ADDR_W-1:0] A_MARK = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stb,
   input  logic              cyc,
   input  logic              we,
   input  logic [ADDR_W-1:0] adr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ack,
   output line_ctrl_t        line_q,
   output logic [STATUS_W-1:0] mask_q,
   output logic [CNT_W-1:0]  mark_q
);
   generate
      if (STATUS_W > DATA_W) begin : g_bad_status
         $error("shk_regs: STATUS_W must not exceed DATA_W");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("shk_regs: CNT_W must not exceed DATA_W");
      end
      if (LINE_W > DATA_W) begin : g_bad_line
         $error("shk_regs: DATA_W too narrow for line control");
      end
   endgenerate

   logic              req;
   logic              wr;
   logic [DATA_W-1:0] rd_n;

   assign req = stb && cyc && !ack;
   assign wr  = req && we;

   always_comb begin
      rd_n = '0;
      if (adr == A_LINE) begin
         rd_n[LINE_W-1:0] = line_q;
      end else if (adr == A_MASK) begin
         rd_n[STATUS_W-1:0] = mask_q;
      end else if (adr == A_MARK) begin
         rd_n[CNT_W-1:0] = mark_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ack    <= 1'b0;
         rdata  <= '0;
         line_q <= '0;
         mask_q <= '0;
         mark_q <= '0;
      end else begin
         ack <= req;
         if (req) begin
            rdata <= rd_n;
         end
         if (wr && adr == A_LINE) begin
            line_q <= line_ctrl_t'(wdata[LINE_W-1:0]);
         end
         if (wr && adr == A_MASK) begin
            mask_q <= wdata[STATUS_W-1:0];
         end
         if (wr && adr == A_MARK) begin
            mark_q <= wdata[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/shk_rts_gen.sv
`timescale 1ns/1ps
module shk_rts_gen
   import shk_pkg::*;
#(
   parameter int CNT_W          = 6,
   parameter bit MARK_INCLUSIVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  line_ctrl_t       line,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] mark,
   output logic             rts
);
   logic over;

   generate
      if (MARK_INCLUSIVE) begin : g_incl
         assign over = (count >= mark);
      end else begin : g_strict
         assign over = (count > mark);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         rts <= 1'b0;
      end else if (line.force_rts) begin
         rts <= line.rts_val;
      end else begin
         rts <= over;
      end
   end
endmodule

// File: rtl/shk_irq_reduce.sv
`timescale 1ns/1ps
module shk_irq_reduce #(
   parameter int STATUS_W = 8,
   parameter int GROUP_W  = 4,
   localparam int NGRP    = STATUS_W / GROUP_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [STATUS_W-1:0] status,
   input  logic [STATUS_W-1:0] mask,
   output logic [NGRP-1:0]     irq
);
   generate
      if (STATUS_W % GROUP_W != 0) begin : g_bad_group
         $error("shk_irq_reduce: STATUS_W must be a multiple of GROUP_W");
      end
   endgenerate

   logic [STATUS_W-1:0] live;
   logic [NGRP-1:0]     hit;

   assign live = status & mask;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign hit[g] = |live[g*GROUP_W +: GROUP_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq <= '0;
      end else begin
         irq <= hit;
      end
   end
endmodule

// File: rtl/shk_top.sv
`timescale 1ns/1ps
module shk_top
   import shk_pkg::*;
#(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter int STATUS_W       = 8,
   parameter int IRQ_GROUP_W    = 4,
   parameter int CNT_W          = 6,
   parameter bit MARK_INCLUSIVE = 1'b0,
   localparam int IRQ_W         = STATUS_W / IRQ_GROUP_W
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                bus_stb,
   input  logic                bus_cyc,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_adr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_ack,
   input  logic [STATUS_W-1:0] stat_in,
   input  logic [CNT_W-1:0]    rx_count,
   input  logic                tx_busy,
   output logic                tx_permit,
   input  logic                cts_n,
   output logic                rts,
   output logic [IRQ_W-1:0]    irq
);
   line_ctrl_t          line_q;
   logic [STATUS_W-1:0] mask_q;
   logic [CNT_W-1:0]    mark_q;

   shk_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STATUS_W(STATUS_W), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst(rst),
      .stb(bus_stb), .cyc(bus_cyc), .we(bus_we),
      .adr(bus_adr), .wdata(bus_wdata),
      .rdata(bus_rdata), .ack(bus_ack),
      .line_q(line_q), .mask_q(mask_q), .mark_q(mark_q)
   );

   shk_rts_gen #(
      .CNT_W(CNT_W), .MARK_INCLUSIVE(MARK_INCLUSIVE)
   ) u_rts (
      .clk(clk), .rst(rst), .line(line_q),
      .count(rx_count), .mark(mark_q), .rts(rts)
   );

   shk_irq_reduce #(
      .STATUS_W(STATUS_W), .GROUP_W(IRQ_GROUP_W)
   ) u_irq (
      .clk(clk), .rst(rst), .status(stat_in), .mask(mask_q), .irq(irq)
   );

   // A character in flight always completes; a new one waits for CTS
   assign tx_permit = tx_busy || !line_q.cts_gate || !cts_n;
endmodule

// File: rtl/shk_checker.sv
`timescale 1ns/1ps
module shk_checker #(
   parameter int CNT_W          = 6,
   parameter bit MARK_INCLUSIVE = 1'b0
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_stb,
   input logic             bus_cyc,
   input logic             bus_ack,
   input logic [7:0]       stat_in,
   input logic [CNT_W-1:0] rx_count,
   input logic             tx_busy,
   input logic             cts_n,
   input logic             tx_permit,
   input logic             rts,
   input logic [1:0]       irq,
   input logic             gate,
   input logic             force_rts,
   input logic             rts_val,
   input logic [CNT_W-1:0] mark
);
   logic above;
   assign above = MARK_INCLUSIVE ? (rx_count >= mark) : (rx_count > mark);

   a_r1_ack_follows: assert property (@(posedge clk) disable iff (rst)
      (bus_stb && bus_cyc && !bus_ack) |=> bus_ack);
   a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
      bus_ack |=> !bus_ack);
   a_r3_tx_irq_quiet: assert property (@(posedge clk) disable iff (rst)
      (stat_in[3:0] == 4'h0) |=> !irq[0]);
   a_r4_rx_irq_quiet: assert property (@(posedge clk) disable iff (rst)
      (stat_in[7:4] == 4'h0) |=> !irq[1]);
   a_r5_cts_hold: assert property (@(posedge clk) disable iff (rst)
      (gate && cts_n && !tx_busy) |-> !tx_permit);
   a_r6_busy_finishes: assert property (@(posedge clk) disable iff (rst)
      tx_busy |-> tx_permit);
   a_r7_forced: assert property (@(posedge clk) disable iff (rst)
      force_rts |=> (rts == $past(rts_val)));
   a_r8_below_mark: assert property (@(posedge clk) disable iff (rst)
      (!force_rts && !above) |=> !rts);
   a_r8_above_mark: assert property (@(posedge clk) disable iff (rst)
      (!force_rts && above) |=> rts);
   a_r9_reset_clear: assert property (@(posedge clk)
      rst |=> (!rts && irq == 2'b00 && !bus_ack));
endmodule

bind shk_top shk_checker #(.CNT_W(CNT_W), .MARK_INCLUSIVE(MARK_INCLUSIVE)) u_chk (
   .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_cyc(bus_cyc),
   .bus_ack(bus_ack), .stat_in(stat_in), .rx_count(rx_count),
   .tx_busy(tx_busy), .cts_n(cts_n), .tx_permit(tx_permit),
   .rts(rts), .irq(irq), .gate(line_q.cts_gate),
   .force_rts(line_q.force_rts), .rts_val(line_q.rts_val), .mark(mark_q)
);

// File: tb/test_shk_top.sv
`timescale 1ns/1ps
module test_shk_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_stb = 0, bus_cyc = 0, bus_we = 0;
   logic [3:0] bus_adr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       bus_ack;
   logic [7:0] stat_in = '0;
   logic [5:0] rx_count = '0;
   logic       tx_busy = 0, cts_n = 1;
   logic       tx_permit, rts;
   logic [1:0] irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   shk_top i_shk_top (
      .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_cyc(bus_cyc),
      .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack), .stat_in(stat_in),
      .rx_count(rx_count), .tx_busy(tx_busy), .tx_permit(tx_permit),
      .cts_n(cts_n), .rts(rts), .irq(irq)
   );

   typedef struct packed {
      logic [7:0] st;
      logic [7:0] mask;
      logic [5:0] cnt;
      logic [5:0] mark;
      logic [2:0] line;   // {rts_val, force, gate}
      logic       cts;
      logic       busy;
      logic [1:0] e_irq;
      logic       e_rts;
      logic       e_ok;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{8'h01, 8'h01, 6'd0,  6'd16, 3'b000, 1'b1, 1'b0, 2'b01, 1'b0, 1'b1},
      '{8'h10, 8'h0F, 6'd32, 6'd16, 3'b001, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0},
      '{8'h10, 8'hF0, 6'd16, 6'd16, 3'b001, 1'b0, 1'b0, 2'b10, 1'b0, 1'b1},
      '{8'h80, 8'h80, 6'd17, 6'd16, 3'b001, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1},
      '{8'hFF, 8'h00, 6'd63, 6'd0,  3'b010, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1},
      '{8'h08, 8'h08, 6'd0,  6'd63, 3'b110, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1},
      '{8'h81, 8'h81, 6'd63, 6'd63, 3'b100, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1},
      '{8'h0F, 8'hF0, 6'd1,  6'd0,  3'b101, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0},
      '{8'hF0, 8'h0F, 6'd5,  6'd6,  3'b011, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1},
      '{8'h24, 8'h2C, 6'd40, 6'd39, 3'b111, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // R1: ack must be seen at the negedge after the accepting edge
   task automatic bus_access(input logic we, input logic [3:0] a,
                             input logic [7:0] d, output logic [7:0] q);
      @(negedge clk);
      bus_stb = 1; bus_cyc = 1; bus_we = we; bus_adr = a; bus_wdata = d;
      @(negedge clk);
      q = bus_rdata;
      check("R1 ack", {7'd0, bus_ack}, 8'd1);
      bus_stb = 0; bus_cyc = 0; bus_we = 0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      logic [7:0] q;
      bus_access(1'b1, a, d, q);
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] q);
      bus_access(1'b0, a, 8'h00, q);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] q;
      repeat (3) @(negedge clk);
      rst = 0;

      // R9: reset state
      check("R9 rts", {7'd0, rts}, 8'd0);
      check("R9 irq", {6'd0, irq}, 8'd0);
      check("R9 ack", {7'd0, bus_ack}, 8'd0);
      rd(4'd0, q); check("R9 line", q, 8'h00);
      rd(4'd1, q); check("R9 mask", q, 8'h00);
      rd(4'd2, q); check("R9 mark", q, 8'h00);

      // Vector table: R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         wr(4'd0, {5'd0, VECS[i].line});
         wr(4'd1, VECS[i].mask);
         wr(4'd2, {2'd0, VECS[i].mark});
         @(negedge clk);
         stat_in = VECS[i].st; rx_count = VECS[i].cnt;
         cts_n = VECS[i].cts; tx_busy = VECS[i].busy;
         #1;
         check("R5/R6 permit", {7'd0, tx_permit}, {7'd0, VECS[i].e_ok});
         @(negedge clk);
         check("R3/R4 irq", {6'd0, irq}, {6'd0, VECS[i].e_irq});
         check("R7/R8 rts", {7'd0, rts}, {7'd0, VECS[i].e_rts});
      end

      // R1: access held high is acknowledged for one cycle only
      @(negedge clk);
      bus_stb = 1; bus_cyc = 1; bus_we = 0; bus_adr = 4'd1;
      check("R1 no early ack", {7'd0, bus_ack}, 8'd0);
      @(negedge clk);
      check("R1 ack next", {7'd0, bus_ack}, 8'd1);
      @(negedge clk);
      check("R1 ack width", {7'd0, bus_ack}, 8'd0);
      bus_stb = 0; bus_cyc = 0;

      // R2: readback, widths, unmapped address
      wr(4'd0, 8'hFF); rd(4'd0, q); check("R2 line width", q, 8'h07);
      wr(4'd1, 8'hA5); rd(4'd1, q); check("R2 mask", q, 8'hA5);
      wr(4'd2, 8'hFF); rd(4'd2, q); check("R2 mark width", q, 8'h3F);
      wr(4'd15, 8'h00); rd(4'd15, q); check("R2 unmapped read", q, 8'h00);
      rd(4'd1, q); check("R2 unmapped write no effect", q, 8'hA5);
      rd(4'd0, q); check("R2 line kept", q, 8'h07);

      // R10: one-edge latency on irq and rts
      wr(4'd0, 8'h00); wr(4'd1, 8'hFF); wr(4'd2, 8'd10);
      @(negedge clk);
      stat_in = 8'h00; rx_count = 6'd10;
      @(negedge clk);
      check("R10 irq idle", {6'd0, irq}, 8'd0);
      check("R10 rts idle", {7'd0, rts}, 8'd0);
      stat_in = 8'h40; rx_count = 6'd11;
      #1;
      check("R10 irq not yet", {6'd0, irq}, 8'd0);
      check("R10 rts not yet", {7'd0, rts}, 8'd0);
      @(negedge clk);
      check("R10 irq after edge", {6'd0, irq}, 8'h02);
      check("R8 rts just above", {7'd0, rts}, 8'd1);

      // R5: live CTS with gating on
      wr(4'd0, 8'h01);
      @(negedge clk);
      tx_busy = 0; cts_n = 1; #1;
      check("R5 cts high blocks", {7'd0, tx_permit}, 8'd0);
      cts_n = 0; #1;
      check("R5 cts low allows", {7'd0, tx_permit}, 8'd1);
      cts_n = 1; tx_busy = 1; #1;
      check("R6 busy finishes", {7'd0, tx_permit}, 8'd1);
      tx_busy = 0;

      // R9: reset during operation
      wr(4'd0, 8'h06);
      @(negedge clk);
      rst = 1;
      @(negedge clk);
      rst = 0;
      check("R9 rts after reset", {7'd0, rts}, 8'd0);
      check("R9 irq after reset", {6'd0, irq}, 8'd0);
      rd(4'd0, q); check("R9 line cleared", q, 8'h00);
      rd(4'd1, q); check("R9 mask cleared", q, 8'h00);

      finish_run();
   end
endmodule